// File: doc/BRIEF.md
# Configurable Cache Tag Controller

This block keeps the tag state of a unified cache that holds instruction fetches and data accesses alike, and it reports for every access whether it hits or misses. The cache is looked up with the virtual word address as presented. Translation belongs to the path between the cache and backing memory, so the lookup path has no translation stage. The block holds only tags, valid bits and replacement ages. Data storage and the backing memory sit outside it.

Geometry is set at elaboration by three parameters: total block count, ways per set and words per block. Sets are block count divided by ways, so one way gives a direct-mapped cache and ways equal to the block count gives a fully associative one. A parameter picks the replacement policy: oldest-filled (FIFO) or least-recently-used (LRU). All three geometry parameters must be powers of two, and ways may not exceed blocks. Any other value stops elaboration.

Writes go through to backing memory on every access, and a write that misses allocates its block the same way a read miss does. A request may be presented every cycle. Its result, its fill request and its write-through request all appear together one clock later.

Top module: `cache_tag_ctrl`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses, and the result outputs stay low until a request is accepted.
- R2: A request accepted at a clock edge gives `rsp_valid` high for exactly the following cycle, with exactly one of `rsp_hit` and `rsp_miss` set. With no request, all strobes are low.
- R3: Address split, counted from bit 0: log2(words per block) offset bits, then log2(sets) set-index bits, and the remaining upper bits form the tag. Two addresses that differ only in offset bits fall in the same block.
- R4: A miss raises `fill_valid` in the same cycle as `rsp_miss`, and `fill_addr` is the request address with its offset bits cleared. A hit raises no fill.
- R5: Every write, hit or miss, raises `wt_valid` in its result cycle, with `wt_addr` equal to the request address. A read never raises `wt_valid`.
- R6: A write miss is reported as a miss and installs its block, so a later access to that block hits.
- R7: With requests on consecutive cycles, each lookup sees the tag installed by the previous cycle's miss.
- R8: In a direct-mapped cache, two blocks with the same set index evict each other, while blocks in different sets stay resident together.
- R9: On a miss, an invalid way of the set is filled before any valid way is evicted.
- R10: Under FIFO the victim is the way filled longest ago, and hits do not change that order.
- R11: Under LRU the victim is the way accessed longest ago, and every hit makes its way the most recent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Access request present this cycle |
| req_addr | input | ADDR_W | Virtual word address of the access |
| req_write | input | 1 | 1 = write, 0 = read or fetch |
| rsp_valid | output | 1 | Result of the request accepted at the previous edge |
| rsp_hit | output | 1 | That request hit |
| rsp_miss | output | 1 | That request missed |
| fill_valid | output | 1 | Block fetch request to backing memory |
| fill_addr | output | ADDR_W | Block-aligned address to fetch |
| wt_valid | output | 1 | Write-through request to backing memory |
| wt_addr | output | ADDR_W | Word address to write through |

## Verification
A write that misses starts two actions in the same result cycle: a block fetch for the allocation and the write-through of the word. The bench provokes this by writing to a block that was never loaded. It then checks that the miss strobe, the fill request with the aligned block address and the write-through with the full word address all appear together in that one sampled cycle. A later read of the block must hit and raise no write-through. The same coincidence is provoked on back-to-back requests, where a write hit arrives in the cycle right after the miss that installed its block.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

  typedef enum logic {
    REPL_FIFO = 1'b0,
    REPL_LRU  = 1'b1
  } repl_e;

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/cache_tag_match.sv
// Parallel tag compare for one set plus lowest-invalid-way search.
module cache_tag_match #(
  parameter int WAYS  = 1,
  parameter int TAG_W = 26,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [TAG_W-1:0] row_tag [WAYS],
  input  logic [WAYS-1:0]  row_vld,
  input  logic [TAG_W-1:0] look_tag,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic             free_any,
  output logic [WAY_W-1:0] free_way
);

  logic [WAYS-1:0] hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = row_vld[w] && (row_tag[w] == look_tag);
  end

  assign hit      = |hit_vec;
  assign free_any = ~&row_vld;

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (hit_vec[i]) hit_way = WAY_W'(i);
    end
  end

  // Lowest numbered invalid way wins.
  always_comb begin
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!row_vld[i]) free_way = WAY_W'(i);
    end
  end

endmodule

// File: rtl/cache_tag_age.sv
// Per-way age ranking for one set. Age 0 is the newest, WAYS-1 the oldest.
// The ages of a set always form a permutation of 0..WAYS-1.
module cache_tag_age #(
  parameter int WAYS  = 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int AGE_W = WAY_W
) (
  input  logic [AGE_W-1:0] age_in  [WAYS],
  input  logic             touch,
  input  logic [WAY_W-1:0] touch_way,
  output logic [AGE_W-1:0] age_out [WAYS],
  output logic [WAY_W-1:0] oldest_way
);

  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

  logic [AGE_W-1:0] touch_age;

  always_comb begin
    touch_age = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (WAY_W'(i) == touch_way) touch_age = age_in[i];
    end
  end

  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      age_out[i] = age_in[i];
      if (touch) begin
        if (WAY_W'(i) == touch_way)      age_out[i] = '0;
        else if (age_in[i] < touch_age)  age_out[i] = age_in[i] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (age_in[i] == AGE_MAX) oldest_way = WAY_W'(i);
    end
  end

endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import cache_tag_pkg::*;
#(
  parameter int    ADDR_W          = 32,
  parameter int    NUM_BLOCKS      = 4,
  parameter int    NUM_WAYS        = 1,
  parameter int    WORDS_PER_BLOCK = 4,
  parameter repl_e REPL            = REPL_LRU
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              wt_valid,
  output logic [ADDR_W-1:0] wt_addr
);

  localparam int SETS    = NUM_BLOCKS / NUM_WAYS;
  localparam int OFF_W   = $clog2(WORDS_PER_BLOCK);
  localparam int SET_W   = $clog2(SETS);
  localparam int IDX_W   = (SET_W > 0) ? SET_W : 1;
  localparam int TAG_LSB = OFF_W + SET_W;
  localparam int TAG_W   = ADDR_W - TAG_LSB;
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
  localparam int AGE_W   = WAY_W;
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((64'd1 << OFF_W) - 64'd1);

  // Geometry checks at elaboration.
  if (!is_pow2(NUM_BLOCKS) || !is_pow2(NUM_WAYS) || !is_pow2(WORDS_PER_BLOCK)) begin : g_bad_pow2
    $error("cache_tag_ctrl: geometry parameters must be powers of two");
  end
  if (NUM_WAYS > NUM_BLOCKS) begin : g_bad_ways
    $error("cache_tag_ctrl: ways exceed block count");
  end
  if (TAG_W < 1) begin : g_bad_tag
    $error("cache_tag_ctrl: address too narrow for geometry");
  end

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  // Tag, valid and age storage.
  logic [TAG_W-1:0]    tag_q [SETS][NUM_WAYS];
  logic [NUM_WAYS-1:0] vld_q [SETS];
  logic [AGE_W-1:0]    age_q [SETS][NUM_WAYS];

  // Address split.
  logic [IDX_W-1:0] set_idx;
  logic [TAG_W-1:0] req_tag;

  if (SET_W == 0) begin : g_one_set
    assign set_idx = '0;
  end else begin : g_many_sets
    assign set_idx = req_addr[OFF_W +: SET_W];
  end
  assign req_tag = req_addr[ADDR_W-1:TAG_LSB];

  // Selected set row.
  logic [TAG_W-1:0]    row_tag [NUM_WAYS];
  logic [AGE_W-1:0]    row_age [NUM_WAYS];
  logic [NUM_WAYS-1:0] row_vld;

  always_comb begin
    row_vld = vld_q[set_idx];
    for (int w = 0; w < NUM_WAYS; w++) begin
      row_tag[w] = tag_q[set_idx][w];
      row_age[w] = age_q[set_idx][w];
    end
  end

  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic             free_any;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] oldest_way;
  logic [WAY_W-1:0] fill_way;
  logic [WAY_W-1:0] use_way;
  logic             age_touch;
  logic [AGE_W-1:0] nxt_age [NUM_WAYS];
  logic [NUM_WAYS-1:0] nxt_vld;

  cache_tag_match #(
    .WAYS  (NUM_WAYS),
    .TAG_W (TAG_W)
  ) match_i (
    .row_tag  (row_tag),
    .row_vld  (row_vld),
    .look_tag (req_tag),
    .hit      (hit),
    .hit_way  (hit_way),
    .free_any (free_any),
    .free_way (free_way)
  );

  assign fill_way = free_any ? free_way : oldest_way;
  assign use_way  = hit ? hit_way : fill_way;

  // FIFO ages move only on fills; LRU ages move on every access.
  if (REPL == REPL_LRU) begin : g_lru
    assign age_touch = req_valid;
  end else begin : g_fifo
    assign age_touch = req_valid && !hit;
  end

  cache_tag_age #(
    .WAYS (NUM_WAYS)
  ) age_i (
    .age_in     (row_age),
    .touch      (age_touch),
    .touch_way  (use_way),
    .age_out    (nxt_age),
    .oldest_way (oldest_way)
  );

  // Next-state for the valid row.
  always_comb begin
    nxt_vld = row_vld;
    if (!hit) nxt_vld[fill_way] = 1'b1;
  end

  // State registers; only the addressed set is written, gated by req_valid.
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
          age_q[s][w] <= AGE_W'(w);
        end
      end
    end else if (req_valid) begin
      vld_q[set_idx] <= nxt_vld;
      for (int w = 0; w < NUM_WAYS; w++) begin
        age_q[set_idx][w] <= nxt_age[w];
      end
    end
  end

  // Tags need no reset: valid bits qualify them.
  always_ff @(posedge clk) begin
    if (req_valid && !hit) begin
      tag_q[set_idx][fill_way] <= req_tag;
    end
  end

  // Result stage.
  logic              rsp_valid_d, rsp_hit_d, rsp_miss_d, fill_valid_d, wt_valid_d;
  logic [ADDR_W-1:0] fill_addr_d;

  always_comb begin
    rsp_valid_d  = req_valid;
    rsp_hit_d    = req_valid && hit;
    rsp_miss_d   = req_valid && !hit;
    fill_valid_d = req_valid && !hit;
    wt_valid_d   = req_valid && req_write;
    fill_addr_d  = req_addr & ~OFF_MASK;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      fill_valid <= 1'b0;
      wt_valid   <= 1'b0;
    end else begin
      rsp_valid  <= rsp_valid_d;
      rsp_hit    <= rsp_hit_d;
      rsp_miss   <= rsp_miss_d;
      fill_valid <= fill_valid_d;
      wt_valid   <= wt_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      fill_addr <= '0;
      wt_addr   <= '0;
    end else if (req_valid) begin
      fill_addr <= fill_addr_d;
      wt_addr   <= req_addr;
    end
  end

endmodule

// File: rtl/cache_tag_ctrl_chk.sv
module cache_tag_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic              fill_valid,
  input logic [ADDR_W-1:0] fill_addr,
  input logic              wt_valid,
  input logic [ADDR_W-1:0] wt_addr
);

  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((64'd1 << OFF_W) - 64'd1);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_hit && !rsp_miss && !fill_valid && !wt_valid);

  p_one_report_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss}) == 1);

  p_fill_with_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (fill_valid == rsp_miss));

  p_fill_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> ((fill_addr & OFF_MASK) == '0));

  p_write_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> wt_valid && (wt_addr == $past(req_addr)));

  p_no_wt_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |=> !wt_valid);

  p_refill_seen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && $past(req_valid) &&
    ((req_addr >> OFF_W) == ($past(req_addr) >> OFF_W)) |=> rsp_hit);

endmodule

bind cache_tag_ctrl cache_tag_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_miss   (rsp_miss),
  .fill_valid (fill_valid),
  .fill_addr  (fill_addr),
  .wt_valid   (wt_valid),
  .wt_addr    (wt_addr)
);

// File: tb/cache_tag_ctrl_tb_top.sv
module cache_tag_ctrl_tb_top;
  import cache_tag_pkg::*;

  localparam int AW = 32;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic          req_write;

  // Index 0: default direct-mapped, 1: 4-way FIFO, 2: 4-way LRU.
  logic [2:0]    rv, rh, rm, fv, wv;
  logic [AW-1:0] fa [3];
  logic [AW-1:0] wa [3];

  int checks = 0;
  int errors = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  cache_tag_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .rsp_valid(rv[0]), .rsp_hit(rh[0]), .rsp_miss(rm[0]),
    .fill_valid(fv[0]), .fill_addr(fa[0]), .wt_valid(wv[0]), .wt_addr(wa[0])
  );

  cache_tag_ctrl #(.NUM_BLOCKS(8), .NUM_WAYS(4), .WORDS_PER_BLOCK(2), .REPL(REPL_FIFO)) dut_fifo (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .rsp_valid(rv[1]), .rsp_hit(rh[1]), .rsp_miss(rm[1]),
    .fill_valid(fv[1]), .fill_addr(fa[1]), .wt_valid(wv[1]), .wt_addr(wa[1])
  );

  cache_tag_ctrl #(.NUM_BLOCKS(8), .NUM_WAYS(4), .WORDS_PER_BLOCK(2), .REPL(REPL_LRU)) dut_lru (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .rsp_valid(rv[2]), .rsp_hit(rh[2]), .rsp_miss(rm[2]),
    .fill_valid(fv[2]), .fill_addr(fa[2]), .wt_valid(wv[2]), .wt_addr(wa[2])
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic do_reset();
    req_valid = 1'b0;
    req_addr  = '0;
    req_write = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // One access; returns at the negedge where its result is visible.
  task automatic access(input logic [AW-1:0] a, input logic w);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 rsp_valid idle after reset", AW'(rv), '0);
    check("R1 hit idle after reset", AW'(rh), '0);
    access(32'h0, 1'b0);
    check("R1 first access misses (all)", AW'(rm), 32'h7);
    check("R2 one report per access", AW'({31'd0, rh[0]} + {31'd0, rm[0]}), 32'd1);
    check("R2 rsp_valid set", AW'(rv), 32'h7);
    @(negedge clk);
    check("R2 rsp_valid drops with no request", AW'(rv), '0);
  endtask

  task automatic t_addr_split();
    do_reset();
    access(32'h1, 1'b0);
    check("R3 offset 1 miss", AW'(rm[0]), 1);
    access(32'h3, 1'b0);
    check("R3 same block other offset hits", AW'(rh[0]), 1);
    check("R4 no fill on hit", AW'(fv[0]), 0);
    access(32'h7, 1'b0);
    check("R3 next set misses", AW'(rm[0]), 1);
    check("R4 fill raised on miss", AW'(fv[0]), 1);
    check("R4 fill address aligned", fa[0], 32'h4);
    check("R5 read raises no write-through", AW'(wv[0]), 0);
  endtask

  task automatic t_conflict();
    do_reset();
    access(32'h00, 1'b0);
    access(32'h10, 1'b0);
    check("R8 same set different tag misses", AW'(rm[0]), 1);
    access(32'h00, 1'b0);
    check("R8 evicted block misses again", AW'(rm[0]), 1);
    access(32'h04, 1'b0);
    check("R8 other set miss", AW'(rm[0]), 1);
    access(32'h00, 1'b0);
    check("R8 blocks in different sets coexist", AW'(rh[0]), 1);
  endtask

  task automatic t_write_alloc();
    do_reset();
    access(32'h21, 1'b1);
    check("R6 write miss reported as miss", AW'(rm[0]), 1);
    check("R5 write-through on write miss", AW'(wv[0]), 1);
    check("R5 write-through address", wa[0], 32'h21);
    check("R6 write miss fills", AW'(fv[0]), 1);
    check("R6 write miss fill address", fa[0], 32'h20);
    access(32'h22, 1'b0);
    check("R6 read after write miss hits", AW'(rh[0]), 1);
    check("R5 no write-through on read", AW'(wv[0]), 0);
    access(32'h23, 1'b1);
    check("R5 write hit still writes through", AW'(wv[0]), 1);
    check("R5 write hit reported hit", AW'(rh[0]), 1);
  endtask

  task automatic t_back_to_back();
    do_reset();
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h40; req_write = 1'b0;
    @(negedge clk);
    check("R7 first of pair misses", AW'(rm[0]), 1);
    req_addr = 32'h41; req_write = 1'b1;
    @(negedge clk);
    check("R7 next-cycle lookup sees fill", AW'(rh[0]), 1);
    check("R7 write-through alongside hit", AW'(wv[0]), 1);
    req_addr = 32'h50; req_write = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R6 write miss in stream", AW'(rm[0]), 1);
    check("R5 fill and write-through same cycle", AW'({fv[0], wv[0]}), 32'h3);
    check("R5 write-through address in stream", wa[0], 32'h50);
  endtask

  // Associative DUTs: block b at address 2*b; even b share set 0.
  task automatic t_invalid_first();
    do_reset();
    for (int b = 0; b < 4; b++) access(AW'(b * 4), 1'b0);
    check("R9 four fills all miss (fifo,lru)", AW'({rm[2], rm[1]}), 32'h3);
    for (int b = 0; b < 4; b++) begin
      access(AW'(b * 4), 1'b0);
      check("R9 invalid ways filled before eviction", AW'({rh[2], rh[1]}), 32'h3);
    end
  endtask

  task automatic t_policy();
    do_reset();
    for (int b = 0; b < 4; b++) access(AW'(b * 4), 1'b0);
    access(32'h0, 1'b0);
    check("R10 R11 hit on block 0", AW'({rh[2], rh[1]}), 32'h3);
    access(32'h10, 1'b0);
    check("R10 R11 fifth block misses", AW'({rm[2], rm[1]}), 32'h3);
    access(32'h0, 1'b0);
    check("R10 fifo evicted oldest fill despite hit", AW'(rm[1]), 1);
    check("R11 lru kept recently hit block", AW'(rh[2]), 1);
    access(32'h4, 1'b0);
    check("R11 lru evicted least recent block", AW'(rm[2]), 1);
    access(32'h2, 1'b0);
    check("R3 other set untouched misses", AW'({rm[2], rm[1]}), 32'h3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    req_write = 1'b0;
    t_reset_state();
    t_addr_split();
    t_conflict();
    t_write_alloc();
    t_back_to_back();
    t_invalid_first();
    t_policy();
    finish_run();
  end

endmodule